// File: doc/BRIEF.md
# Page operation sequencer

This block carries out the self-timed array work of a serial page-organised flash memory once the serial front end has captured a command. The front end decodes the command and raises a one-cycle `start` strobe on the chip-select release, with the opcode and the page number alongside it. From then on the block runs the command's phases without any further input. A phase is one of: copy a page into the page buffer, compare a page with the buffer, erase a page, erase a block of pages, program the buffer into a page with or without an earlier erase, or a chain of these. Each phase moves one byte per clock between a behavioural array and the buffer. It then holds for a cycle count, set by a parameter, that stands in for the physical erase or program time.

The buffer is inside the block. The front end loads and reads it through a host port, and reads the array through a second host port for page reads. While an operation runs, the block pulls its ready/busy line low (`rb_low` high). Host writes to the buffer have no effect during that time. A compare leaves its result in `cmp_diff` until the next compare. With the write-protect input low, no command can alter the lower half of the array.

Top module: `page_op_sequencer`

## Requirements
- R1: While `rst_n` is low and after it rises, `rb_low` and `cmp_diff` are 0.
- R2: Opcode 0x53 copies the selected page into the buffer and leaves the array unchanged. `rb_low` is high for exactly T_XFR cycles.
- R3: Opcode 0x60 compares all bytes of the selected page with the buffer. At the end `cmp_diff` is 0 when every bit matches and 1 when any bit differs, including a difference in the last byte only. Busy lasts T_XFR cycles, and neither the buffer nor the array changes.
- R4: Opcodes 0x83 and 0x82 erase the selected page and then program the buffer into it. The page ends equal to the buffer, and busy lasts T_ERS+T_PRG cycles.
- R5: Opcode 0x88 programs without an erase. Each page byte becomes the bitwise AND of its old value and the buffer byte, and busy lasts T_PRG cycles.
- R6: Opcode 0x81 sets every byte of the selected page to 0xFF, leaves the other pages unchanged, and is busy for T_ERS cycles.
- R7: Opcode 0x50 sets to 0xFF all pages whose page number shares bits [PA_W-1:3] with the selected page. The low 3 bits are ignored, the other pages are unchanged, and busy lasts T_BLK cycles.
- R8: Opcode 0x58 copies the page into the buffer, erases the page and programs it back. Afterwards the buffer equals the page, the page is unchanged, and busy lasts T_XFR+T_ERS+T_PRG cycles.
- R9: When `wp_n` is 0 at `start`, an altering command (0x83, 0x82, 0x88, 0x81, 0x50, 0x58) aimed at a page below PAGES/2 never raises `rb_low` and changes nothing. The same commands on upper pages, and 0x53/0x60 on any page, run normally.
- R10: `rb_low` rises in the cycle after an accepted `start`. A `start` while busy is ignored. An opcode outside the list above never raises `rb_low` and changes nothing.
- R11: A host buffer write is applied at the next clock edge when the block is idle and ignored while `rb_low` is high.
- R12: `rst_n` low aborts the running operation at once and clears `rb_low`. Array bytes already written keep their new values, and the others keep their old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle command strobe from the front end |
| opcode | input | 8 | Captured command code |
| page_sel | input | $clog2(PAGES) | Captured target page |
| wp_n | input | 1 | Write protect of the lower half, active low |
| host_buf_we | input | 1 | Host buffer write enable |
| host_buf_addr | input | $clog2(PAGE_BYTES) | Host buffer byte index |
| host_buf_wdata | input | 8 | Host buffer write byte |
| host_buf_rdata | output | 8 | Buffer byte at `host_buf_addr` |
| host_page | input | $clog2(PAGES) | Array page for host read |
| host_byte | input | $clog2(PAGE_BYTES) | Array byte for host read |
| host_arr_rdata | output | 8 | Array byte at `host_page`/`host_byte` |
| rb_low | output | 1 | High while busy: pull-down enable of the ready/busy line |
| cmp_diff | output | 1 | Result of the latest compare, 1 = mismatch |

## Verification
The hardest situation to reach from the ports is an operation cut short by reset partway through its byte moves, where the page is left part-erased. The bench counts clock cycles from the accepted strobe and drops reset after a known number of byte writes. It then predicts exactly which bytes are 0xFF and which keep their old value. A second hard case is a collision: a new strobe and a host buffer write land in the middle of a running copy. The bench injects them at a fixed cycle of the busy window, then shows through the host ports that neither had any effect.

// File: rtl/po_pkg.sv
package po_pkg;

   localparam logic [7:0] OP_XFER     = 8'h53;
   localparam logic [7:0] OP_CMP      = 8'h60;
   localparam logic [7:0] OP_ERS_PGM  = 8'h83;
   localparam logic [7:0] OP_LOAD_PGM = 8'h82;
   localparam logic [7:0] OP_AND_PGM  = 8'h88;
   localparam logic [7:0] OP_ERS_PAGE = 8'h81;
   localparam logic [7:0] OP_ERS_BLK  = 8'h50;
   localparam logic [7:0] OP_REWRITE  = 8'h58;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_XFER,
      PH_CMP,
      PH_ERASE,
      PH_BERASE,
      PH_PROG,
      PH_PAND
   } phase_e;

   typedef struct packed {
      logic   known;
      logic   alters;
      phase_e p0;
      phase_e p1;
      phase_e p2;
   } plan_t;

   function automatic plan_t plan_of(logic [7:0] op);
      plan_t p;
      p = '{known: 1'b1, alters: 1'b1, p0: PH_IDLE, p1: PH_IDLE, p2: PH_IDLE};
      case (op)
         OP_XFER:     begin p.alters = 1'b0; p.p0 = PH_XFER; end
         OP_CMP:      begin p.alters = 1'b0; p.p0 = PH_CMP; end
         OP_ERS_PGM,
         OP_LOAD_PGM: begin p.p0 = PH_ERASE; p.p1 = PH_PROG; end
         OP_AND_PGM:  p.p0 = PH_PAND;
         OP_ERS_PAGE: p.p0 = PH_ERASE;
         OP_ERS_BLK:  p.p0 = PH_BERASE;
         OP_REWRITE:  begin p.p0 = PH_XFER; p.p1 = PH_ERASE; p.p2 = PH_PROG; end
         default:     begin p.known = 1'b0; p.alters = 1'b0; end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/po_bytemem.sv
module po_bytemem #(
   parameter int DEPTH = 192,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] ra_addr,
   output logic [7:0]    ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [7:0]    rb_data
);

   localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

   logic [7:0] mem [DEPTH];

   if (DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_depth
      $error("po_bytemem: DEPTH does not fit AW");
   end

   always_ff @(posedge clk) begin
      if (we && ({1'b0, waddr} < DEPTH_W)) mem[waddr] <= wdata;
   end

   if (DEPTH == (1 << AW)) begin : g_full
      assign ra_data = mem[ra_addr];
      assign rb_data = mem[rb_addr];
   end else begin : g_guard
      assign ra_data = ({1'b0, ra_addr} < DEPTH_W) ? mem[ra_addr] : 8'h00;
      assign rb_data = ({1'b0, rb_addr} < DEPTH_W) ? mem[rb_addr] : 8'h00;
   end

endmodule

// File: rtl/po_ctrl.sv
module po_ctrl
   import po_pkg::*;
#(
   parameter int PAGES      = 16,
   parameter int PAGE_BYTES = 12,
   parameter int BLK_PAGES  = 8,
   parameter int T_XFR      = 16,
   parameter int T_ERS      = 20,
   parameter int T_PRG      = 24,
   parameter int T_BLK      = 100,
   parameter bit WP_EN      = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [7:0]                    opcode,
   input  logic [$clog2(PAGES)-1:0]      page_in,
   input  logic                          wp_n,
   input  logic [7:0]                    arr_rdata,
   input  logic [7:0]                    buf_rdata,
   output logic                          busy,
   output logic                          cmp_diff,
   output logic [$clog2(PAGES)-1:0]      mv_page,
   output logic [$clog2(PAGE_BYTES)-1:0] mv_byte,
   output logic                          arr_we,
   output logic [7:0]                    arr_wdata,
   output logic                          buf_we,
   output logic [7:0]                    buf_wdata
);

   localparam int PA_W  = $clog2(PAGES);
   localparam int BY_W  = $clog2(PAGE_BYTES);
   localparam int BK_W  = $clog2(BLK_PAGES);
   localparam int T_M1  = (T_XFR > T_ERS) ? T_XFR : T_ERS;
   localparam int T_M2  = (T_PRG > T_BLK) ? T_PRG : T_BLK;
   localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
   localparam int CNT_W = $clog2(T_MAX + 1);
   localparam logic [BY_W-1:0] LAST_BYTE = BY_W'(PAGE_BYTES - 1);
   localparam logic [BK_W-1:0] LAST_SUB  = BK_W'(BLK_PAGES - 1);

   if (PAGES != (1 << PA_W) || PAGES < 2 * BLK_PAGES) begin : g_bad_pages
      $error("po_ctrl: PAGES must be a power of two holding at least two blocks");
   end
   if (BLK_PAGES != (1 << BK_W) || BLK_PAGES < 2) begin : g_bad_blk
      $error("po_ctrl: BLK_PAGES must be a power of two of at least 2");
   end
   if (PAGE_BYTES < 2) begin : g_bad_bytes
      $error("po_ctrl: PAGE_BYTES must be at least 2");
   end
   if (T_XFR < PAGE_BYTES || T_ERS < PAGE_BYTES || T_PRG < PAGE_BYTES ||
       T_BLK < BLK_PAGES * PAGE_BYTES) begin : g_bad_time
      $error("po_ctrl: a phase is shorter than its byte moves");
   end

   phase_e              ph_q, nx1_q, nx2_q;
   logic [CNT_W-1:0]    dwell_q;
   logic [BY_W-1:0]     byte_q;
   logic [BK_W-1:0]     sub_q;
   logic                moved_q;
   logic [PA_W-1:0]     page_q;
   logic                diff_acc_q;
   logic                cmp_q;

   plan_t               plan;
   logic                prot;
   logic                accept;
   logic                moving;
   logic                last_move;
   logic                phase_end;
   logic                diff_now;

   function automatic logic [CNT_W-1:0] lim_of(phase_e ph);
      case (ph)
         PH_XFER, PH_CMP:  return CNT_W'(T_XFR - 1);
         PH_ERASE:         return CNT_W'(T_ERS - 1);
         PH_BERASE:        return CNT_W'(T_BLK - 1);
         PH_PROG, PH_PAND: return CNT_W'(T_PRG - 1);
         default:          return '0;
      endcase
   endfunction

   assign plan = plan_of(opcode);

   // Protection variant: the lower half of the array is guarded while wp_n is low.
   if (WP_EN) begin : g_wp
      assign prot = !wp_n && !page_in[PA_W-1];

      // R9: an erase aimed at a guarded page never raises busy.
      a_r9_guarded_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (start && !busy && !wp_n && !page_in[PA_W-1] && opcode == OP_ERS_PAGE) |=> !busy);
   end else begin : g_nowp
      assign prot = 1'b0;
   end

   assign accept    = start && (ph_q == PH_IDLE) && plan.known && !(plan.alters && prot);
   assign moving    = (ph_q != PH_IDLE) && !moved_q;
   assign last_move = (byte_q == LAST_BYTE) && ((ph_q != PH_BERASE) || (sub_q == LAST_SUB));
   assign phase_end = (ph_q != PH_IDLE) && (dwell_q == lim_of(ph_q));
   assign diff_now  = moving && (ph_q == PH_CMP) && (arr_rdata != buf_rdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         nx1_q      <= PH_IDLE;
         nx2_q      <= PH_IDLE;
         dwell_q    <= '0;
         byte_q     <= '0;
         sub_q      <= '0;
         moved_q    <= 1'b0;
         page_q     <= '0;
         diff_acc_q <= 1'b0;
         cmp_q      <= 1'b0;
      end else if (accept) begin
         ph_q       <= plan.p0;
         nx1_q      <= plan.p1;
         nx2_q      <= plan.p2;
         page_q     <= page_in;
         dwell_q    <= '0;
         byte_q     <= '0;
         sub_q      <= '0;
         moved_q    <= 1'b0;
         diff_acc_q <= 1'b0;
      end else if (phase_end) begin
         if (ph_q == PH_CMP) cmp_q <= diff_acc_q | diff_now;
         ph_q    <= nx1_q;
         nx1_q   <= nx2_q;
         nx2_q   <= PH_IDLE;
         dwell_q <= '0;
         byte_q  <= '0;
         sub_q   <= '0;
         moved_q <= 1'b0;
      end else if (ph_q != PH_IDLE) begin
         dwell_q <= dwell_q + 1'b1;
         if (diff_now) diff_acc_q <= 1'b1;
         if (moving) begin
            if (byte_q == LAST_BYTE) begin
               byte_q <= '0;
               if (last_move) moved_q <= 1'b1;
               else           sub_q   <= sub_q + 1'b1;
            end else begin
               byte_q <= byte_q + 1'b1;
            end
         end
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign cmp_diff = cmp_q;
   assign mv_byte  = byte_q;
   assign mv_page  = (ph_q == PH_BERASE) ? {page_q[PA_W-1:BK_W], sub_q} : page_q;

   always_comb begin
      arr_we    = 1'b0;
      arr_wdata = 8'hFF;
      case (ph_q)
         PH_ERASE, PH_BERASE: arr_we = moving;
         PH_PROG:  begin arr_we = moving; arr_wdata = buf_rdata; end
         PH_PAND:  begin arr_we = moving; arr_wdata = buf_rdata & arr_rdata; end
         default:  arr_we = 1'b0;
      endcase
   end

   assign buf_we    = moving && (ph_q == PH_XFER);
   assign buf_wdata = arr_rdata;

   // R10: an accepted copy command raises busy in the next cycle.
   a_r10_copy_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && opcode == OP_XFER) |=> busy);

   // R10: busy never rises without a strobe.
   a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R3: the compare result holds while the block is idle.
   a_r3_result_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(cmp_diff));

endmodule

// File: rtl/page_op_sequencer.sv
module page_op_sequencer #(
   parameter int PAGES      = 16,
   parameter int PAGE_BYTES = 12,
   parameter int BLK_PAGES  = 8,
   parameter int T_XFR      = 16,
   parameter int T_ERS      = 20,
   parameter int T_PRG      = 24,
   parameter int T_BLK      = 100,
   parameter bit WP_EN      = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [7:0]                    opcode,
   input  logic [$clog2(PAGES)-1:0]      page_sel,
   input  logic                          wp_n,
   input  logic                          host_buf_we,
   input  logic [$clog2(PAGE_BYTES)-1:0] host_buf_addr,
   input  logic [7:0]                    host_buf_wdata,
   output logic [7:0]                    host_buf_rdata,
   input  logic [$clog2(PAGES)-1:0]      host_page,
   input  logic [$clog2(PAGE_BYTES)-1:0] host_byte,
   output logic [7:0]                    host_arr_rdata,
   output logic                          rb_low,
   output logic                          cmp_diff
);

   localparam int DEPTH = PAGES * PAGE_BYTES;
   localparam int AW    = $clog2(DEPTH);
   localparam int PA_W  = $clog2(PAGES);
   localparam int BY_W  = $clog2(PAGE_BYTES);

   logic            busy;
   logic [PA_W-1:0] mv_page;
   logic [BY_W-1:0] mv_byte;
   logic            arr_we, seq_buf_we;
   logic [7:0]      arr_wdata, seq_buf_wdata;
   logic [7:0]      arr_rdata, buf_rdata;
   logic [AW-1:0]   seq_addr, host_addr;
   logic            buf_we;
   logic [BY_W-1:0] buf_waddr;
   logic [7:0]      buf_wdata;

   po_ctrl #(
      .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .BLK_PAGES(BLK_PAGES),
      .T_XFR(T_XFR), .T_ERS(T_ERS), .T_PRG(T_PRG), .T_BLK(T_BLK), .WP_EN(WP_EN)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .opcode    (opcode),
      .page_in   (page_sel),
      .wp_n      (wp_n),
      .arr_rdata (arr_rdata),
      .buf_rdata (buf_rdata),
      .busy      (busy),
      .cmp_diff  (cmp_diff),
      .mv_page   (mv_page),
      .mv_byte   (mv_byte),
      .arr_we    (arr_we),
      .arr_wdata (arr_wdata),
      .buf_we    (seq_buf_we),
      .buf_wdata (seq_buf_wdata)
   );

   assign seq_addr  = AW'(mv_page) * AW'(PAGE_BYTES) + AW'(mv_byte);
   assign host_addr = AW'(host_page) * AW'(PAGE_BYTES) + AW'(host_byte);

   // The sequencer owns the buffer while busy; host writes land only when idle.
   assign buf_we    = seq_buf_we | (host_buf_we & ~busy);
   assign buf_waddr = seq_buf_we ? mv_byte : host_buf_addr;
   assign buf_wdata = seq_buf_we ? seq_buf_wdata : host_buf_wdata;

   po_bytemem #(.DEPTH(DEPTH), .AW(AW)) u_array (
      .clk     (clk),
      .we      (arr_we),
      .waddr   (seq_addr),
      .wdata   (arr_wdata),
      .ra_addr (seq_addr),
      .ra_data (arr_rdata),
      .rb_addr (host_addr),
      .rb_data (host_arr_rdata)
   );

   po_bytemem #(.DEPTH(PAGE_BYTES), .AW(BY_W)) u_buffer (
      .clk     (clk),
      .we      (buf_we),
      .waddr   (buf_waddr),
      .wdata   (buf_wdata),
      .ra_addr (mv_byte),
      .ra_data (buf_rdata),
      .rb_addr (host_buf_addr),
      .rb_data (host_buf_rdata)
   );

   assign rb_low = busy;

   // R11: the sequencer never writes the buffer while idle.
   a_r11_seq_buf_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      seq_buf_we |-> rb_low);

endmodule

// File: tb/sim_page_op_sequencer.sv
module sim_page_op_sequencer;

   localparam int NP = 16;
   localparam int NB = 12;
   localparam int BK = 8;
   localparam int TX = 16;
   localparam int TE = 20;
   localparam int TP = 24;
   localparam int TB = 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] opcode = 8'h00;
   logic [3:0] page_sel = '0;
   logic       wp_n = 1'b1;
   logic       host_buf_we = 1'b0;
   logic [3:0] host_buf_addr = '0;
   logic [7:0] host_buf_wdata = '0;
   logic [7:0] host_buf_rdata;
   logic [3:0] host_page = '0;
   logic [3:0] host_byte = '0;
   logic [7:0] host_arr_rdata;
   logic       rb_low;
   logic       cmp_diff;

   int nchk = 0;
   int nerr = 0;
   logic [7:0] m_arr [NP*NB];
   logic [7:0] m_buf [NB];

   always #5 clk = ~clk;

   page_op_sequencer #(
      .PAGES(NP), .PAGE_BYTES(NB), .BLK_PAGES(BK),
      .T_XFR(TX), .T_ERS(TE), .T_PRG(TP), .T_BLK(TB), .WP_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .page_sel(page_sel),
      .wp_n(wp_n), .host_buf_we(host_buf_we), .host_buf_addr(host_buf_addr),
      .host_buf_wdata(host_buf_wdata), .host_buf_rdata(host_buf_rdata),
      .host_page(host_page), .host_byte(host_byte), .host_arr_rdata(host_arr_rdata),
      .rb_low(rb_low), .cmp_diff(cmp_diff)
   );

   function automatic logic [7:0] pat(int seed, int b);
      return 8'((seed * 29 + b * 13 + 7) ^ (b << 4));
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic buf_write(int b, logic [7:0] d);
      @(negedge clk);
      host_buf_we = 1'b1; host_buf_addr = 4'(b); host_buf_wdata = d;
      @(negedge clk);
      host_buf_we = 1'b0;
   endtask

   task automatic load_buf(int seed);
      for (int b = 0; b < NB; b++) begin
         buf_write(b, pat(seed, b));
         m_buf[b] = pat(seed, b);
      end
   endtask

   task automatic check_mem(string req);
      int abad = 0, bbad = 0, aact = 0, aexp = 0, bact = 0, bexp = 0;
      for (int p = 0; p < NP; p++) begin
         for (int b = 0; b < NB; b++) begin
            host_page = 4'(p); host_byte = 4'(b);
            #1;
            if (host_arr_rdata !== m_arr[p*NB+b]) begin
               if (abad == 0) begin aact = host_arr_rdata; aexp = m_arr[p*NB+b]; end
               abad++;
            end
         end
      end
      for (int b = 0; b < NB; b++) begin
         host_buf_addr = 4'(b);
         #1;
         if (host_buf_rdata !== m_buf[b]) begin
            if (bbad == 0) begin bact = host_buf_rdata; bexp = m_buf[b]; end
            bbad++;
         end
      end
      chk(abad == 0, req, "array contents", aact, aexp);
      chk(bbad == 0, req, "buffer contents", bact, bexp);
      @(negedge clk);
   endtask

   // Strobe one command and count the cycles for which busy is seen.
   task automatic run_op(logic [7:0] op, int page, int exp, string req, bit inject);
      int n = 0;
      @(negedge clk);
      start = 1'b1; opcode = op; page_sel = 4'(page);
      @(negedge clk);
      start = 1'b0;
      while (rb_low === 1'b1 && n < 1000) begin
         n++;
         if (inject && n == 3) begin
            start = 1'b1; opcode = 8'h81; page_sel = 4'd0;
            host_buf_we = 1'b1; host_buf_addr = 4'd0; host_buf_wdata = ~m_buf[0];
         end else if (inject && n == 4) begin
            start = 1'b0; host_buf_we = 1'b0;
         end
         @(negedge clk);
      end
      chk(n == exp, req, "busy cycles", n, exp);
   endtask

   task automatic model_erase(int p);
      for (int b = 0; b < NB; b++) m_arr[p*NB+b] = 8'hFF;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(rb_low === 1'b0, "R1", "rb_low in reset", rb_low, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rb_low === 1'b0, "R1", "rb_low after reset", rb_low, 0);
      chk(cmp_diff === 1'b0, "R1", "cmp_diff after reset", cmp_diff, 0);

      // R4: fill every page, alternating the two erase-and-program codes
      for (int p = 0; p < NP; p++) begin
         load_buf(p + 1);
         run_op((p % 2 == 0) ? 8'h83 : 8'h82, p, TE + TP, "R4", 1'b0);
         for (int b = 0; b < NB; b++) m_arr[p*NB+b] = m_buf[b];
         check_mem("R4");
      end

      // R2: copy sweep over all pages
      for (int p = 0; p < NP; p++) begin
         run_op(8'h53, p, TX, "R2", 1'b0);
         for (int b = 0; b < NB; b++) m_buf[b] = m_arr[p*NB+b];
      end
      check_mem("R2");

      // R3: compare match, mismatch, last-byte-only and first-byte-only differences
      run_op(8'h60, NP - 1, TX, "R3", 1'b0);
      chk(cmp_diff === 1'b0, "R3", "match result", cmp_diff, 0);
      run_op(8'h60, NP - 2, TX, "R3", 1'b0);
      chk(cmp_diff === 1'b1, "R3", "mismatch result", cmp_diff, 1);
      buf_write(NB - 1, m_buf[NB-1] ^ 8'h01);
      m_buf[NB-1] = m_buf[NB-1] ^ 8'h01;
      run_op(8'h60, NP - 1, TX, "R3", 1'b0);
      chk(cmp_diff === 1'b1, "R3", "last byte differs", cmp_diff, 1);
      buf_write(NB - 1, m_buf[NB-1] ^ 8'h01);
      m_buf[NB-1] = m_buf[NB-1] ^ 8'h01;
      run_op(8'h60, NP - 1, TX, "R3", 1'b0);
      chk(cmp_diff === 1'b0, "R3", "restored match", cmp_diff, 0);
      buf_write(0, m_buf[0] ^ 8'h80);
      m_buf[0] = m_buf[0] ^ 8'h80;
      run_op(8'h60, NP - 1, TX, "R3", 1'b0);
      chk(cmp_diff === 1'b1, "R3", "first byte differs", cmp_diff, 1);
      check_mem("R3");

      // R5: program without erase ANDs into the page
      load_buf(99);
      run_op(8'h88, 6, TP, "R5", 1'b0);
      for (int b = 0; b < NB; b++) m_arr[6*NB+b] = m_arr[6*NB+b] & m_buf[b];
      check_mem("R5");

      // R6: page erase
      run_op(8'h81, 9, TE, "R6", 1'b0);
      model_erase(9);
      check_mem("R6");

      // R7: block erase with low page bits ignored (page 13 selects pages 8..15)
      run_op(8'h50, 13, TB, "R7", 1'b0);
      for (int p = 8; p < 16; p++) model_erase(p);
      check_mem("R7");

      // R8: auto rewrite leaves the page and copies it to the buffer
      load_buf(50);
      run_op(8'h58, 4, TX + TE + TP, "R8", 1'b0);
      for (int b = 0; b < NB; b++) m_buf[b] = m_arr[4*NB+b];
      check_mem("R8");

      // R9: protection sweep with program-without-erase over all pages
      wp_n = 1'b0;
      load_buf(77);
      for (int p = 0; p < NP; p++) begin
         run_op(8'h88, p, (p >= NP/2) ? TP : 0, "R9", 1'b0);
         if (p >= NP/2)
            for (int b = 0; b < NB; b++) m_arr[p*NB+b] = m_arr[p*NB+b] & m_buf[b];
      end
      check_mem("R9");
      run_op(8'h81, 3, 0, "R9", 1'b0);
      run_op(8'h50, 0, 0, "R9", 1'b0);
      run_op(8'h83, 7, 0, "R9", 1'b0);
      run_op(8'h82, 5, 0, "R9", 1'b0);
      run_op(8'h58, 2, 0, "R9", 1'b0);
      check_mem("R9");
      run_op(8'h53, 2, TX, "R9", 1'b0);
      for (int b = 0; b < NB; b++) m_buf[b] = m_arr[2*NB+b];
      run_op(8'h83, 12, TE + TP, "R9", 1'b0);
      for (int b = 0; b < NB; b++) m_arr[12*NB+b] = m_buf[b];
      check_mem("R9");
      wp_n = 1'b1;

      // R10: unknown opcode does nothing
      run_op(8'h57, 1, 0, "R10", 1'b0);
      check_mem("R10");

      // R10 and R11: strobe and host write injected mid-copy are ignored
      run_op(8'h53, 5, TX, "R10", 1'b1);
      for (int b = 0; b < NB; b++) m_buf[b] = m_arr[5*NB+b];
      check_mem("R11");

      // R12: reset during the erase phase after four byte writes
      load_buf(7);
      run_op(8'h60, 4, TX, "R12", 1'b0);
      chk(cmp_diff === 1'b1, "R12", "compare before abort", cmp_diff, 1);
      @(negedge clk);
      start = 1'b1; opcode = 8'h83; page_sel = 4'd4;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(rb_low === 1'b0, "R12", "busy cleared by reset", rb_low, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rb_low === 1'b0, "R12", "idle after abort", rb_low, 0);
      chk(cmp_diff === 1'b0, "R12", "compare cleared", cmp_diff, 0);
      for (int b = 0; b < 4; b++) m_arr[4*NB+b] = 8'hFF;
      check_mem("R12");
      run_op(8'h53, 4, TX, "R12", 1'b0);
      for (int b = 0; b < NB; b++) m_buf[b] = m_arr[4*NB+b];
      check_mem("R12");

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule